// File: doc/BRIEF.md
# Elliptic-curve scalar multiply sequencer

This block is the top-level controller for computing the point multiple kP with the left-to-right double-and-add method. It neither stores coordinates nor does field arithmetic. It steers an external point-arithmetic unit through the point-double and point-add operations that the scalar calls for, and it drives the register strobes that load the base point into that unit.

A job is a scalar handed in over a valid/ready input. The sequencer first loads the X coordinate and clears Z in one step, then loads Y in the next. It then skips the scalar's leading zero bits. The first one-bit found seeds the accumulator with the base point. Each bit after that costs one double, and each of those bits that is one costs an add as well. The scalar is consumed by shifting it left, so the most significant bit is always the one tested. Each command is a one-cycle strobe, and the sequencer waits for the matching done pulse before it moves on.

The end of a job is signalled with a one-cycle completion pulse. A job ends when all bits are used, or early when the halt input is seen at a bit boundary. A scalar of zero ends with the point-at-infinity flag set. Two counters report how many doubles and adds were issued. In the control, states that need no outside event advance by themselves on an internal advance condition. The command-wait states advance only on the done events.

Top module: `ec_kp_sequencer`

## Requirements
- R1: A job is accepted on a rising clock edge where job_valid and job_ready are both 1. job_ready is 1 only while no job is in progress. job_valid and job_scalar are ignored while job_ready is 0.
- R2: In the first cycle after acceptance, load_x and clear_z are both 1 for one cycle. load_y is 1 in the cycle after that. All three are 0 otherwise.
- R3: Zero bits above the most significant one-bit of the scalar cause no command.
- R4: For each bit below the most significant one-bit, taken from the top down, exactly one dbl_req pulse is issued. If that bit is 1, exactly one add_req pulse follows in the cycle after the dbl_done of that double.
- R5: Each command is a one-cycle pulse. At most one command is outstanding at a time. No command is issued until the done of the previous command has been seen.
- R6: At completion, dbl_count equals the number of bits below the most significant one-bit, and add_count equals the number of one-bits in the scalar minus one.
- R7: A scalar of zero issues no command. It ends with kp_done and at_infinity = 1, with both counts 0.
- R8: If halt is 1 when a bit boundary is reached (after the previous bit's double and add have completed), the job ends at once with at_infinity = 0. The counts then reflect only the bits already processed.
- R9: kp_done is a one-cycle pulse. at_infinity is valid in that cycle. job_ready is 1 in the cycle after kp_done.
- R10: dbl_count and add_count are cleared when a job is accepted. They hold their value from completion until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_valid | input | 1 | A scalar is offered on job_scalar |
| job_ready | output | 1 | Sequencer is idle and can take a scalar |
| job_scalar | input | KEY_W | Scalar multiplier k |
| halt | input | 1 | Finish early at the next bit boundary |
| load_x | output | 1 | Strobe: load base X coordinate |
| clear_z | output | 1 | Strobe: clear Z coordinate |
| load_y | output | 1 | Strobe: load base Y coordinate |
| dbl_req | output | 1 | Point-double command pulse |
| dbl_done | input | 1 | Point double finished |
| add_req | output | 1 | Point-add command pulse |
| add_done | input | 1 | Point add finished |
| kp_done | output | 1 | Job complete pulse |
| at_infinity | output | 1 | Result is the point at infinity (valid with kp_done) |
| dbl_count | output | CNT_W | Doubles issued in the current or last job |
| add_count | output | CNT_W | Adds issued in the current or last job |

## Verification
The bench places the only one-bit at the bottom of the scalar. A design that mishandled the end of the leading-zero skip would then issue a stray double, or never finish. It also places the only one-bit at the top and then sets every bit, so that a wrong shift direction or an off-by-one in the bit counter shows up as a command sequence out of order or a count of 259 or 261 instead of 260. A zero scalar must end with the infinity flag and no command. A design that tested the scalar as non-zero would issue doubles instead. A halt raised in the middle of a bit must let that bit's add complete before stopping. A second job offer made while busy must leave the running job's counts unchanged.

// File: rtl/ec_kp_pkg.sv
package ec_kp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDX,
    ST_LDY,
    ST_SKIP,
    ST_TEST,
    ST_DBL,
    ST_ADD,
    ST_FIN
  } kp_state_e;
endpackage

// File: rtl/ec_kp_shifter.sv
module ec_kp_shifter #(
  parameter int KEY_W = 261,
  localparam int CNT_W = $clog2(KEY_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [KEY_W-1:0] scalar,
  output logic             msb,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_W);

  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      key_q  <= scalar;
      left_q <= FULL;
    end else if (shift) begin
      key_q  <= {key_q[KEY_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb   = key_q[KEY_W-1];
  assign empty = (left_q == '0);

  // R3 / R4: the bit counter never wraps below zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !empty);
endmodule

// File: rtl/ec_kp_op_counter.sv
module ec_kp_op_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/ec_kp_fsm.sv
module ec_kp_fsm
  import ec_kp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic job_valid,
  input  logic halt,
  input  logic msb,
  input  logic empty,
  input  logic dbl_done,
  input  logic add_done,
  output logic job_ready,
  output logic load_key,
  output logic shift,
  output logic inc_dbl,
  output logic inc_add,
  output logic load_x,
  output logic clear_z,
  output logic load_y,
  output logic dbl_req,
  output logic add_req,
  output logic kp_done,
  output logic at_infinity
);
  kp_state_e state_q, state_d;
  logic      cur_bit_q;
  logic      adv;       // autonomous advance: state needs no outside event
  logic      go_bit;

  assign adv    = (state_q == ST_LDX) || (state_q == ST_LDY) ||
                  (state_q == ST_SKIP) || (state_q == ST_TEST) || (state_q == ST_FIN);
  assign go_bit = (state_q == ST_TEST) && !empty && !halt;

  assign job_ready = (state_q == ST_IDLE);
  assign load_key  = job_ready && job_valid;
  assign shift     = ((state_q == ST_SKIP) && !empty) || go_bit;
  assign inc_dbl   = go_bit;
  assign inc_add   = (state_q == ST_DBL) && dbl_done && cur_bit_q;
  assign load_x    = (state_q == ST_LDX);
  assign clear_z   = (state_q == ST_LDX);
  assign load_y    = (state_q == ST_LDY);
  assign kp_done   = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (job_valid) state_d = ST_LDX;
      ST_LDX:  if (adv) state_d = ST_LDY;
      ST_LDY:  if (adv) state_d = ST_SKIP;
      ST_SKIP: begin
        if (empty)    state_d = ST_FIN;
        else if (msb) state_d = ST_TEST;
      end
      ST_TEST: state_d = go_bit ? ST_DBL : ST_FIN;
      ST_DBL:  if (dbl_done) state_d = cur_bit_q ? ST_ADD : ST_TEST;
      ST_ADD:  if (add_done) state_d = ST_TEST;
      ST_FIN:  if (adv) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_bit_q   <= 1'b0;
      dbl_req     <= 1'b0;
      add_req     <= 1'b0;
      at_infinity <= 1'b0;
    end else begin
      state_q <= state_d;
      dbl_req <= go_bit;
      add_req <= inc_add;
      if (go_bit) cur_bit_q <= msb;
      if (load_key) at_infinity <= 1'b0;
      else if ((state_q == ST_SKIP) && empty) at_infinity <= 1'b1;
    end
  end

  a_r1_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready) |=> (load_x && clear_z && !job_ready));
  a_r2_y_after_x: assert property (@(posedge clk) disable iff (!rst_n)
    load_x |=> (load_y && !load_x));
  a_r4_add_after_dbl_done: assert property (@(posedge clk) disable iff (!rst_n)
    add_req |-> $past(dbl_done));
  a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbl_req && add_req));
  a_r5_dbl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_req |=> !dbl_req);
  a_r5_add_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    add_req |=> !add_req);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    kp_done |=> (!kp_done && job_ready));
endmodule

// File: rtl/ec_kp_sequencer.sv
module ec_kp_sequencer #(
  parameter int KEY_W = 261,
  localparam int CNT_W = $clog2(KEY_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_valid,
  output logic             job_ready,
  input  logic [KEY_W-1:0] job_scalar,
  input  logic             halt,
  output logic             load_x,
  output logic             clear_z,
  output logic             load_y,
  output logic             dbl_req,
  input  logic             dbl_done,
  output logic             add_req,
  input  logic             add_done,
  output logic             kp_done,
  output logic             at_infinity,
  output logic [CNT_W-1:0] dbl_count,
  output logic [CNT_W-1:0] add_count
);
  logic load_key, shift, msb, empty, inc_dbl, inc_add;

  ec_kp_shifter #(.KEY_W(KEY_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_key), .shift(shift),
    .scalar(job_scalar), .msb(msb), .empty(empty)
  );

  ec_kp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .halt(halt),
    .msb(msb), .empty(empty), .dbl_done(dbl_done), .add_done(add_done),
    .job_ready(job_ready), .load_key(load_key), .shift(shift),
    .inc_dbl(inc_dbl), .inc_add(inc_add), .load_x(load_x),
    .clear_z(clear_z), .load_y(load_y), .dbl_req(dbl_req),
    .add_req(add_req), .kp_done(kp_done), .at_infinity(at_infinity)
  );

  ec_kp_op_counter #(.W(CNT_W)) u_dbl_cnt (
    .clk(clk), .rst_n(rst_n), .clr(load_key), .inc(inc_dbl), .count(dbl_count)
  );

  ec_kp_op_counter #(.W(CNT_W)) u_add_cnt (
    .clk(clk), .rst_n(rst_n), .clr(load_key), .inc(inc_add), .count(add_count)
  );

  a_r7_inf_no_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (kp_done && at_infinity) |-> (dbl_count == '0 && add_count == '0));
  a_r6_adds_le_dbls: assert property (@(posedge clk) disable iff (!rst_n)
    kp_done |-> (add_count <= dbl_count));
endmodule

// File: tb/ec_kp_sequencer_bench.sv
module ec_kp_sequencer_bench;
  localparam int KEY_W = 261;
  localparam int CNT_W = $clog2(KEY_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_valid = 1'b0;
  logic [KEY_W-1:0] job_scalar = '0;
  logic halt = 1'b0;
  logic dbl_done = 1'b0;
  logic add_done = 1'b0;
  logic job_ready, load_x, clear_z, load_y, dbl_req, add_req, kp_done, at_infinity;
  logic [CNT_W-1:0] dbl_count, add_count;

  int checks = 0;
  int failures = 0;
  byte exp_q[$];
  int lat_d = 1;
  int lat_a = 1;
  int d_cnt = 0;
  int a_cnt = 0;
  int dbl_seen = 0;
  int halt_at = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ec_kp_sequencer #(.KEY_W(KEY_W)) u_ec_kp_sequencer (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_scalar(job_scalar), .halt(halt), .load_x(load_x), .clear_z(clear_z),
    .load_y(load_y), .dbl_req(dbl_req), .dbl_done(dbl_done), .add_req(add_req),
    .add_done(add_done), .kp_done(kp_done), .at_infinity(at_infinity),
    .dbl_count(dbl_count), .add_count(add_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor and point-unit model: pops expected commands, answers with done
  initial begin
    forever begin
      @(negedge clk);
      dbl_done = 1'b0;
      add_done = 1'b0;
      if (d_cnt > 0) begin d_cnt--; if (d_cnt == 0) dbl_done = 1'b1; end
      if (a_cnt > 0) begin a_cnt--; if (a_cnt == 0) add_done = 1'b1; end
      if (dbl_req) begin
        // R4 / R5: a double must be the next expected command
        chk(exp_q.size() > 0 && exp_q[0] == 8'h44, "R4 dbl order",
            exp_q.size() > 0 ? int'(exp_q[0]) : 0, 8'h44);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        d_cnt = lat_d;
        dbl_seen++;
        if (halt_at != 0 && dbl_seen == halt_at) halt = 1'b1;
      end
      if (add_req) begin
        chk(exp_q.size() > 0 && exp_q[0] == 8'h41, "R4 add order",
            exp_q.size() > 0 ? int'(exp_q[0]) : 0, 8'h41);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        a_cnt = lat_a;
      end
    end
  end

  // Driver: computes expected command stream, runs one job, checks results
  task automatic run_job(input logic [KEY_W-1:0] s, input int stop_after,
                         input bit poke_busy);
    int lead = -1;
    int nd = 0;
    int na = 0;
    int waited = 0;
    for (int i = KEY_W - 1; i >= 0; i--) if (lead < 0 && s[i]) lead = i;
    if (lead > 0) begin
      for (int i = lead - 1; i >= 0; i--) begin
        if (stop_after != 0 && nd == stop_after) break;
        exp_q.push_back(8'h44); nd++;
        if (s[i]) begin exp_q.push_back(8'h41); na++; end
      end
    end
    dbl_seen = 0;
    halt_at = stop_after;
    @(negedge clk);
    chk(job_ready == 1'b1, "R1 ready idle", job_ready, 1);
    job_valid = 1'b1;
    job_scalar = s;
    @(negedge clk);
    job_valid = 1'b0;
    job_scalar = '0;
    chk(load_x && clear_z && !load_y, "R2 load_x/clear_z", {load_x, clear_z, load_y}, 3'b110);
    chk(dbl_count == 0 && add_count == 0, "R10 counts cleared", dbl_count + add_count, 0);
    @(negedge clk);
    chk(load_y && !load_x && !clear_z, "R2 load_y", {load_x, clear_z, load_y}, 3'b001);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      chk(job_ready == 1'b0, "R1 busy not ready", job_ready, 0);
      job_valid = 1'b1;
      job_scalar = '1;
      @(negedge clk);
      job_valid = 1'b0;
      job_scalar = '0;
    end
    while (!kp_done && waited < 20000) begin @(negedge clk); waited++; end
    chk(kp_done == 1'b1, "R9 kp_done seen", kp_done, 1);
    chk(at_infinity == (lead < 0), "R7/R8 at_infinity", at_infinity, lead < 0);
    chk(int'(dbl_count) == nd, "R6 dbl_count", dbl_count, nd);
    chk(int'(add_count) == na, "R6 add_count", add_count, na);
    chk(exp_q.size() == 0, "R3/R4 all commands issued", exp_q.size(), 0);
    halt = 1'b0;
    halt_at = 0;
    @(negedge clk);
    chk(!kp_done && job_ready, "R9 pulse then ready", {kp_done, job_ready}, 2'b01);
    repeat (4) @(negedge clk);
    chk(int'(dbl_count) == nd && int'(add_count) == na, "R10 counts hold",
        dbl_count, nd);
    exp_q.delete();
  endtask

  initial begin
    logic [KEY_W-1:0] pat;
    repeat (3) @(negedge clk);
    chk(!load_x && !load_y && !dbl_req && !add_req && !kp_done, "R2/R5 reset quiet",
        {load_x, load_y, dbl_req, add_req, kp_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(job_ready == 1'b1, "R1 ready after reset", job_ready, 1);

    // R3: only the lowest bit set, no command
    lat_d = 1; lat_a = 1;
    run_job({{(KEY_W-1){1'b0}}, 1'b1}, 0, 0);
    // R4: only the top bit set, 260 doubles, no adds
    lat_d = 2;
    run_job({1'b1, {(KEY_W-1){1'b0}}}, 0, 0);
    // R6: every bit set
    lat_d = 1; lat_a = 3;
    run_job('1, 0, 0);
    // R7: zero scalar
    run_job('0, 0, 0);
    // R4/R6: mixed pattern with leading zeros; R1: offer while busy
    pat = '0;
    for (int i = 0; i < 200; i++) if ((i % 3 == 0) || (i % 7 == 1)) pat[i] = 1'b1;
    lat_d = 4; lat_a = 2;
    run_job(pat, 0, 1);
    // R8: halt after five doubles of an all-ones scalar
    lat_d = 2; lat_a = 2;
    run_job('1, 5, 0);
    // R8: halt on a double whose bit is zero
    run_job({1'b1, 1'b0, 1'b1, 1'b0, {(KEY_W-4){1'b1}}}, 1, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule